// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single read or write requests from inside a chip into bus cycles on a 16-bit line set that carries the address first and the data after it. For each cycle it drives an address latch strobe, a read strobe, two write/byte strobes, an instruction-fetch flag and a clock-out reference at half the core clock rate. The internal side gives a one-cycle request with a word address, byte enables, write data, a direction bit and a fetch flag. A one-cycle done pulse comes back, with read data that stays valid until the next request is taken.

Each bus cycle takes four core clocks, in the state order ADDR, STRB1, STRB2, FIN. ADDR shows the address and the latch strobe. STRB1 and STRB2 are the strobe window. FIN is the release period. At the end of ADDR the bus width is fixed, either from the width pin or from a configuration bit. At the clock-out rising edge that ends STRB1, the ready pin is sampled. Each low sample adds the pair WAITH, WAITL, and ready is sampled again at the end of WAITL. The controller starts from IDLE and goes through SYNC when one clock is needed to line ADDR up with the clock-out high phase. A word access on a cycle that resolves to 8 bits runs as two byte cycles, going FIN back to ADDR between them.

Configuration pins choose the latch strobe form (one-clock pulse, or an active-low address-valid level) and the write strobe encoding (one strobe per byte lane, or a common write strobe plus a byte-high enable). The pads and the tri-state buffers are outside the block. It gives a per-cycle output enable for the shared lines.

Top module: `xbus_ctl`

## Requirements
- R1: `clkout_o` toggles on every core clock. It is high in the first period of every bus cycle. When a request arrives with clock-out high, one SYNC clock comes before ADDR.
- R2: With ready high at the first sample, a bus cycle lasts exactly 4 core clocks. In its first clock `ad_oe_o`=1 and `ad_out_o` carries the byte address. Bit 0 of that address is 1 only when the cycle serves the high byte alone.
- R3: `ready_i` is sampled at the end of the second period and at the end of each wait pair. Every low sample adds exactly 2 core clocks to the strobe window.
- R4: With `cfg_dyn_width_i`=1, `width_i` is sampled at the end of the first period: 0 gives an 8-bit cycle and 1 gives a 16-bit cycle. With `cfg_dyn_width_i`=0, `cfg_wide_i` decides in the same way and `width_i` has no effect.
- R5: A request with `req_be_i`=11 on an 8-bit cycle runs as two byte cycles back to back. The low byte comes first at the even address, then the high byte at the odd address. There is one done pulse, after the second cycle.
- R6: With `cfg_adv_level_i`=0, `ale_o` is high only in the first period of a cycle and low otherwise. With `cfg_adv_level_i`=1, `ale_o` is low from the first period through the strobe window, and high in the final period and while idle.
- R7: The strobe window is the second period, any wait periods and the third period. `rd_n_o` is low only in the window of a read. The write strobes are low only in the window of a write. All strobes are high outside that window.
- R8: With `cfg_wr_split_i`=1, `wr_lo_n_o` is low only when the low lane (even byte) is written and `wr_hi_n_o` only when the high lane (odd byte) is written. On 16-bit cycles the lanes follow `req_be_i` (bit 0 = low byte). On 8-bit cycles the lane follows address bit 0.
- R9: With `cfg_wr_split_i`=0, `wr_lo_n_o` is low in the window of every write, and `wr_hi_n_o` acts as a byte-high enable: low only when the high lane is written.
- R10: From the second period to the end of a cycle, writes drive data with `ad_oe_o`=1. A 16-bit cycle puts the enabled bytes in their own lanes. An 8-bit cycle puts its byte on bits 7:0. Reads hold `ad_oe_o`=0.
- R11: `inst_o` is high in every period of each cycle of a fetch request and low at all other times.
- R12: `done_o` is a one-clock pulse in the final period of the last cycle. Then `rdata_o` carries the read bytes in their lanes. An 8-bit cycle's byte is taken from bits 7:0. Lanes not enabled read zero.
- R13: A request that arrives while a transfer is in progress is ignored. No extra cycle runs and the transfer in progress keeps its address and direction.
- R14: After reset the block is in IDLE: strobes high, `ad_oe_o`=0, `done_o`=0, `inst_o`=0, `rdata_o`=0, and `ale_o` at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core (oscillator-rate) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dyn_width_i | input | 1 | 1: width taken from `width_i` per cycle |
| cfg_wide_i | input | 1 | Fixed width when not dynamic: 1 = 16-bit |
| cfg_adv_level_i | input | 1 | 1: latch strobe as active-low address-valid level |
| cfg_wr_split_i | input | 1 | 1: per-lane write strobes; 0: write plus byte-high enable |
| req_i | input | 1 | One-clock request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_fetch_i | input | 1 | Request is an instruction fetch |
| req_word_i | input | 15 | Word address (byte address bits 15:1) |
| req_be_i | input | 2 | Byte enables, bit 0 = even byte |
| req_wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| done_o | output | 1 | Transfer complete pulse |
| clkout_o | output | 1 | Clock-out reference, half core rate |
| ale_o | output | 1 | Address latch pulse or address-valid level |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_lo_n_o | output | 1 | Write / write-low strobe, active low |
| wr_hi_n_o | output | 1 | Write-high or byte-high enable, active low |
| inst_o | output | 1 | Instruction-fetch cycle indicator |
| ad_out_o | output | 16 | Value driven on the multiplexed lines |
| ad_oe_o | output | 1 | Output enable for the multiplexed lines |
| ad_in_i | input | 16 | Value read from the multiplexed lines |
| ready_i | input | 1 | Wait-state request, low = wait |
| width_i | input | 1 | Dynamic bus width pin, 1 = 16-bit |

## Verification
The sweep crosses both latch-strobe forms, both write encodings and both width sources with reads and writes, all three byte-enable patterns, both resolved widths and zero to two wait states. It alternates fetch and data requests. Byte enable 11 against a narrow width is the only pattern that exposes the split and its ordering. Patterns 01 and 10 separate lane selection from address bit 0, and the wait counts separate the ready sampling points from a fixed-length window. With the width source fixed, the pin is driven opposite to the configuration bit, which shows it has no effect. A second request injected during each transfer with a different address and direction, followed by a quiet idle stretch, shows that requests arriving while busy are dropped.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    // Bus sequencer states; ADDR..FIN is one bus cycle
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SYNC  = 3'd1,
        ST_ADDR  = 3'd2,
        ST_STRB1 = 3'd3,
        ST_WAITH = 3'd4,
        ST_WAITL = 3'd5,
        ST_STRB2 = 3'd6,
        ST_FIN   = 3'd7
    } bus_state_e;

    // Decoded phase flags shared by the datapath and the strobe generator
    typedef struct packed {
        logic addr_ph;   // first period: address on the lines
        logic strb_ph;   // strobe window incl. waits
        logic fin_ph;    // final release period
        logic capture;   // last strobe period: read data sampled at its end
        logic active;    // any period of a bus cycle
    } bus_phase_t;

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       ready_i,
    input  logic       more_i,
    output bus_phase_t phase_o,
    output logic       accept_o,
    output logic       done_o,
    output logic       clkout_o
);

    bus_state_e state_q, state_d;
    logic       clk_ph_q;

    // state register and clock-out divider
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            clk_ph_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            clk_ph_q <= ~clk_ph_q;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i) state_d = clk_ph_q ? ST_SYNC : ST_ADDR;
            ST_SYNC:  state_d = ST_ADDR;
            ST_ADDR:  state_d = ST_STRB1;
            ST_STRB1: state_d = ready_i ? ST_STRB2 : ST_WAITH;
            ST_WAITH: state_d = ST_WAITL;
            ST_WAITL: state_d = ready_i ? ST_STRB2 : ST_WAITH;
            ST_STRB2: state_d = ST_FIN;
            ST_FIN:   state_d = more_i ? ST_ADDR : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        phase_o  = '0;
        accept_o = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept_o = req_i;
            ST_SYNC:  ;
            ST_ADDR:  begin phase_o.addr_ph = 1'b1; phase_o.active = 1'b1; end
            ST_STRB1,
            ST_WAITH,
            ST_WAITL: begin phase_o.strb_ph = 1'b1; phase_o.active = 1'b1; end
            ST_STRB2: begin
                phase_o.strb_ph = 1'b1;
                phase_o.capture = 1'b1;
                phase_o.active  = 1'b1;
            end
            ST_FIN:   begin
                phase_o.fin_ph = 1'b1;
                phase_o.active = 1'b1;
                done_o         = ~more_i;
            end
            default:  ;
        endcase
    end

    assign clkout_o = clk_ph_q;

    AST_ADDR_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |-> clkout_o); // R1

    AST_WAIT_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAITH) |=> (state_q == ST_WAITL)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R12

endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
    import xbus_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bus_phase_t         phase_i,
    input  logic               accept_i,
    input  logic               cfg_dyn_width_i,
    input  logic               cfg_wide_i,
    input  logic               width_i,
    input  logic               req_write_i,
    input  logic               req_fetch_i,
    input  logic [BUS_W-2:0]   req_word_i,
    input  logic [1:0]         req_be_i,
    input  logic [BUS_W-1:0]   req_wdata_i,
    input  logic [BUS_W-1:0]   ad_in_i,
    output logic [BUS_W-1:0]   ad_out_o,
    output logic               ad_oe_o,
    output logic [BUS_W-1:0]   rdata_o,
    output logic               more_o,
    output logic               lane_lo_o,
    output logic               lane_hi_o,
    output logic               write_o,
    output logic               fetch_o
);

    localparam int LANES  = 2;
    localparam int BYTE_W = BUS_W / LANES;

    logic [BUS_W-2:0] word_q;
    logic [BUS_W-1:0] wdata_q;
    logic [1:0]       be_q;
    logic             write_q, fetch_q, narrow_q, second_q;
    logic             cyc_a0;
    logic [BUS_W-1:0] data_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q   <= '0;
            wdata_q  <= '0;
            be_q     <= '0;
            write_q  <= 1'b0;
            fetch_q  <= 1'b0;
            narrow_q <= 1'b0;
            second_q <= 1'b0;
        end else begin
            if (accept_i) begin
                word_q   <= req_word_i;
                wdata_q  <= req_wdata_i;
                be_q     <= req_be_i;
                write_q  <= req_write_i;
                fetch_q  <= req_fetch_i;
                second_q <= 1'b0;
            end
            if (phase_i.addr_ph)
                narrow_q <= second_q ? 1'b1
                          : (cfg_dyn_width_i ? ~width_i : ~cfg_wide_i);
            if (phase_i.fin_ph && more_o)
                second_q <= 1'b1;
        end
    end

    // byte address bit 0 of the current cycle
    assign cyc_a0    = second_q | (be_q == 2'b10);
    assign more_o    = narrow_q & (be_q == 2'b11) & ~second_q;
    assign lane_lo_o = narrow_q ? ~cyc_a0 : be_q[0];
    assign lane_hi_o = narrow_q ?  cyc_a0 : be_q[1];
    assign write_o   = write_q;
    assign fetch_o   = fetch_q;

    // the byte an 8-bit cycle needs always sits on the low lane
    assign data_word = cyc_a0 ? {wdata_q[BUS_W-1 -: BYTE_W], wdata_q[BUS_W-1 -: BYTE_W]}
                              : wdata_q;

    always_comb begin
        ad_out_o = '0;
        ad_oe_o  = 1'b0;
        if (phase_i.addr_ph) begin
            ad_out_o = {word_q, cyc_a0};
            ad_oe_o  = 1'b1;
        end else if ((phase_i.strb_ph || phase_i.fin_ph) && write_q) begin
            ad_out_o = data_word;
            ad_oe_o  = 1'b1;
        end
    end

    // per-lane read capture
    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic              take;
        logic [BYTE_W-1:0] byte_q;
        assign take = narrow_q ? (cyc_a0 == (L == 1)) : be_q[L];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= '0;
            else if (accept_i)
                byte_q <= '0;
            else if (phase_i.capture && !write_q && take)
                byte_q <= narrow_q ? ad_in_i[BYTE_W-1:0] : ad_in_i[L*BYTE_W +: BYTE_W];
        end
        assign rdata_o[L*BYTE_W +: BYTE_W] = byte_q;
    end

    AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        phase_i.strb_ph |=> (phase_i.strb_ph ? $stable(narrow_q) : 1'b1)); // R4

    AST_SPLIT_ONLY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(second_q) |-> (narrow_q && be_q == 2'b11)); // R5

    AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i.strb_ph && !accept_i) |=> ($stable(word_q) && $stable(write_q))); // R13

endmodule

// File: rtl/xbus_strobe.sv
module xbus_strobe
    import xbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_phase_t phase_i,
    input  logic       cfg_adv_level_i,
    input  logic       cfg_wr_split_i,
    input  logic       write_i,
    input  logic       fetch_i,
    input  logic       lane_lo_i,
    input  logic       lane_hi_i,
    output logic       ale_o,
    output logic       rd_n_o,
    output logic       wr_lo_n_o,
    output logic       wr_hi_n_o,
    output logic       inst_o
);

    logic wr_win, rd_win;

    assign wr_win = phase_i.strb_ph &  write_i;
    assign rd_win = phase_i.strb_ph & ~write_i;

    always_comb begin
        ale_o     = cfg_adv_level_i ? ~(phase_i.addr_ph | phase_i.strb_ph)
                                    :    phase_i.addr_ph;
        rd_n_o    = ~rd_win;
        wr_lo_n_o = ~(wr_win & (cfg_wr_split_i ? lane_lo_i : 1'b1));
        wr_hi_n_o = ~(wr_win & lane_hi_i);
        inst_o    = phase_i.active & fetch_i;
    end

    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && (!wr_lo_n_o || !wr_hi_n_o))); // R7

    AST_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_i.active |-> (rd_n_o && wr_lo_n_o && wr_hi_n_o && !inst_o)); // R7

endmodule

// File: rtl/xbus_ctl.sv
module xbus_ctl
    import xbus_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_dyn_width_i,
    input  logic             cfg_wide_i,
    input  logic             cfg_adv_level_i,
    input  logic             cfg_wr_split_i,
    input  logic             req_i,
    input  logic             req_write_i,
    input  logic             req_fetch_i,
    input  logic [BUS_W-2:0] req_word_i,
    input  logic [1:0]       req_be_i,
    input  logic [BUS_W-1:0] req_wdata_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic             done_o,
    output logic             clkout_o,
    output logic             ale_o,
    output logic             rd_n_o,
    output logic             wr_lo_n_o,
    output logic             wr_hi_n_o,
    output logic             inst_o,
    output logic [BUS_W-1:0] ad_out_o,
    output logic             ad_oe_o,
    input  logic [BUS_W-1:0] ad_in_i,
    input  logic             ready_i,
    input  logic             width_i
);

    bus_phase_t phase;
    logic       accept, more, lane_lo, lane_hi, cur_write, cur_fetch;

    xbus_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .ready_i  (ready_i),
        .more_i   (more),
        .phase_o  (phase),
        .accept_o (accept),
        .done_o   (done_o),
        .clkout_o (clkout_o)
    );

    xbus_lane #(.BUS_W(BUS_W)) u_lane (
        .clk             (clk),
        .rst_n           (rst_n),
        .phase_i         (phase),
        .accept_i        (accept),
        .cfg_dyn_width_i (cfg_dyn_width_i),
        .cfg_wide_i      (cfg_wide_i),
        .width_i         (width_i),
        .req_write_i     (req_write_i),
        .req_fetch_i     (req_fetch_i),
        .req_word_i      (req_word_i),
        .req_be_i        (req_be_i),
        .req_wdata_i     (req_wdata_i),
        .ad_in_i         (ad_in_i),
        .ad_out_o        (ad_out_o),
        .ad_oe_o         (ad_oe_o),
        .rdata_o         (rdata_o),
        .more_o          (more),
        .lane_lo_o       (lane_lo),
        .lane_hi_o       (lane_hi),
        .write_o         (cur_write),
        .fetch_o         (cur_fetch)
    );

    xbus_strobe u_strobe (
        .clk             (clk),
        .rst_n           (rst_n),
        .phase_i         (phase),
        .cfg_adv_level_i (cfg_adv_level_i),
        .cfg_wr_split_i  (cfg_wr_split_i),
        .write_i         (cur_write),
        .fetch_i         (cur_fetch),
        .lane_lo_i       (lane_lo),
        .lane_hi_i       (lane_hi),
        .ale_o           (ale_o),
        .rd_n_o          (rd_n_o),
        .wr_lo_n_o       (wr_lo_n_o),
        .wr_hi_n_o       (wr_hi_n_o),
        .inst_o          (inst_o)
    );

endmodule

// File: tb/xbus_ctl_test.sv
module xbus_ctl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dyn, cfg_wide, cfg_adv, cfg_split;
    logic        req, req_write, req_fetch;
    logic [14:0] req_word;
    logic [1:0]  req_be;
    logic [15:0] req_wdata;
    logic [15:0] rdata;
    logic        done, clkout, ale, rd_n, wr_lo_n, wr_hi_n, inst, ad_oe;
    logic [15:0] ad_out, ad_in;
    logic        ready, width;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xbus_ctl uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_dyn_width_i(cfg_dyn), .cfg_wide_i(cfg_wide),
        .cfg_adv_level_i(cfg_adv), .cfg_wr_split_i(cfg_split),
        .req_i(req), .req_write_i(req_write), .req_fetch_i(req_fetch),
        .req_word_i(req_word), .req_be_i(req_be), .req_wdata_i(req_wdata),
        .rdata_o(rdata), .done_o(done), .clkout_o(clkout), .ale_o(ale),
        .rd_n_o(rd_n), .wr_lo_n_o(wr_lo_n), .wr_hi_n_o(wr_hi_n), .inst_o(inst),
        .ad_out_o(ad_out), .ad_oe_o(ad_oe), .ad_in_i(ad_in),
        .ready_i(ready), .width_i(width)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] bytef(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // one transfer, watched period by period from the pins
    task automatic do_access(input bit wr, input bit fetch, input logic [1:0] be,
                             input bit wide_exp, input int w, input logic [15:0] base,
                             input logic [15:0] wd);
        int          ncyc, cyc, i, dones, n_ale, n_strb, inst_bad, done_bad, idle_bad, fin_at;
        bit          started, prev_ale, prev_clk, a0, lo, hi, narrow, fin_seen;
        logic [15:0] caddr, mask, exp_rd;
        logic [7:0]  wbyte;
        narrow = !wide_exp;
        ncyc   = (narrow && be == 2'b11) ? 2 : 1;
        fin_at = 3 + 2 * w;
        cyc = -1; i = 0; dones = 0; n_ale = 0; n_strb = 0;
        inst_bad = 0; done_bad = 0; idle_bad = 0; fin_seen = 0;
        prev_ale = cfg_adv; prev_clk = clkout;
        caddr = base;
        req_write = wr; req_fetch = fetch; req_be = be;
        req_word = base[15:1]; req_wdata = wd; req = 1'b1;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            started = cfg_adv ? (!ale && prev_ale) : ale;
            if (started) begin
                cyc++; i = 0; n_ale = 0; n_strb = 0;
                a0 = (cyc == 1) || (be == 2'b10);
                caddr = {base[15:1], a0};
                chk(clkout == 1'b1, "R1 clkout high in address period", clkout, 1);
                chk(ad_oe && ad_out == caddr, "R2 address on lines", {ad_oe, ad_out}, {1'b1, caddr});
                chk(inst == fetch, "R11 inst in address period", inst, fetch);
            end else if (cyc >= 0) begin
                i++;
            end
            if (cyc >= 0 && i <= fin_at) begin
                if (cfg_adv ? !ale : ale) n_ale++;
                if (!(rd_n && wr_lo_n && wr_hi_n)) n_strb++;
                if (inst != fetch) inst_bad++;
                if (done != ((cyc == ncyc - 1) && i == fin_at)) done_bad++;
                if (i == 1) begin
                    lo = narrow ? !a0 : be[0];
                    hi = narrow ?  a0 : be[1];
                    chk(rd_n == wr, "R7 read strobe", rd_n, wr);
                    if (cfg_split)
                        chk(wr_lo_n == !(wr && lo), "R8 low-lane write strobe", wr_lo_n, !(wr && lo));
                    else
                        chk(wr_lo_n == !wr, "R9 common write strobe", wr_lo_n, !wr);
                    chk(wr_hi_n == !(wr && hi), cfg_split ? "R8 high-lane write strobe" : "R9 byte-high enable",
                        wr_hi_n, !(wr && hi));
                    if (wr) begin
                        if (narrow) begin
                            wbyte = a0 ? wd[15:8] : wd[7:0];
                            chk(ad_oe && ad_out[7:0] == wbyte, "R10 byte write data", {ad_oe, ad_out[7:0]}, {1'b1, wbyte});
                        end else begin
                            mask = {{8{be[1]}}, {8{be[0]}}};
                            chk(ad_oe && (ad_out & mask) == (wd & mask), "R10 word write data",
                                {ad_oe, ad_out & mask}, {1'b1, wd & mask});
                        end
                    end else begin
                        chk(ad_oe == 1'b0, "R10 lines released on read", ad_oe, 0);
                    end
                end
                if (i == fin_at) begin
                    fin_seen = 1;
                    chk(n_strb == 2 + 2 * w, "R3 strobe window length", n_strb, 2 + 2 * w);
                    chk(n_ale == (cfg_adv ? fin_at : 1), "R6 latch strobe periods", n_ale, cfg_adv ? fin_at : 1);
                    chk(rd_n && wr_lo_n && wr_hi_n, "R7 strobes released in final period",
                        {rd_n, wr_lo_n, wr_hi_n}, 3'b111);
                end
            end else if (cyc == ncyc - 1 && i > fin_at) begin
                if (!rd_n || !wr_lo_n || !wr_hi_n || ad_oe || inst || done || ale != cfg_adv) idle_bad++;
                if (clkout == prev_clk) idle_bad++;
            end
            if (done) begin
                dones++;
                if (!wr) begin
                    exp_rd = {be[1] ? bytef(base | 16'h1) : 8'h00, be[0] ? bytef(base & 16'hFFFE) : 8'h00};
                    chk(rdata == exp_rd, "R12 read data", rdata, exp_rd);
                end
            end
            prev_ale = ale;
            prev_clk = clkout;
            // drive for the next edge
            req = (cyc == 0 && i == 1);
            if (req) begin
                req_word = ~base[15:1]; req_write = ~wr;
            end else begin
                req_word = base[15:1]; req_write = wr;
            end
            ready = (cyc >= 0) && (i >= 2 * w + 1);
            ad_in = narrow ? {8'hEE, bytef(caddr)}
                           : {bytef(caddr | 16'h1), bytef(caddr & 16'hFFFE)};
            if (cyc == ncyc - 1 && i == fin_at + 6) break;
        end
        req = 1'b0;
        chk(cyc == ncyc - 1 && fin_seen, "R5 byte cycle count", cyc + 1, ncyc);
        chk(dones == 1 && done_bad == 0, "R12 single done pulse", dones, 1);
        chk(inst_bad == 0, "R11 inst over whole cycle", inst_bad, 0);
        chk(idle_bad == 0, "R13 no cycle after ignored request", idle_bad, 0);
    endtask

    initial begin
        int n = 0;
        bit wide_exp;
        logic [15:0] base;
        cfg_dyn = 0; cfg_wide = 1; cfg_adv = 0; cfg_split = 1;
        req = 0; req_write = 0; req_fetch = 0; req_word = '0; req_be = 2'b11;
        req_wdata = '0; ad_in = '0; ready = 0; width = 1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        chk(rd_n && wr_lo_n && wr_hi_n, "R14 strobes high after reset", {rd_n, wr_lo_n, wr_hi_n}, 3'b111);
        chk(!ad_oe, "R14 lines released after reset", ad_oe, 0);
        chk(!done && !inst, "R14 done and inst low after reset", {done, inst}, 0);
        chk(rdata == 16'h0, "R14 read data clear after reset", rdata, 0);
        chk(ale == 1'b0, "R14 latch strobe idle after reset", ale, 0);
        for (int adv = 0; adv < 2; adv++)
            for (int sp = 0; sp < 2; sp++)
                for (int dy = 0; dy < 2; dy++) begin
                    cfg_adv = adv[0]; cfg_split = sp[0]; cfg_dyn = dy[0];
                    repeat (3) @(negedge clk);
                    for (int wr = 0; wr < 2; wr++)
                        for (int be = 1; be < 4; be++)
                            for (int ws = 0; ws < 2; ws++)
                                for (int w = 0; w < 3; w++) begin
                                    wide_exp = ws[0];
                                    // R4: the unused width source is driven opposite
                                    if (cfg_dyn) begin width = ws[0]; cfg_wide = ~ws[0]; end
                                    else begin cfg_wide = ws[0]; width = ~ws[0]; end
                                    base = (16'h2000 + 16'(n) * 16'h0246) & 16'hFFFE;
                                    do_access(wr[0], n[0], be[1:0], wide_exp, w, base,
                                              {base[7:0] ^ 8'hC3, 8'(n) + 8'h11});
                                    n++;
                                    repeat (n % 2) @(negedge clk);
                                end
                end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog all-requirements act=timeout exp=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule